// File: doc/BRIEF.md
# Extension Bus Slave Cycle Router

This block is the slave side of a cable extension bus interface. When the bus master raises the address strobe, the block captures the address, the address space, the cycle kind, the transfer size and the read/write flag. It also captures the hit outputs of three external decoders: the configuration-space decoder, the memory decoder and the window decoders. It then decides whether the cycle belongs to this module. A claimed cycle is sent to exactly one of three targets: the local register file, the local DRAM, or a request port that feeds a VMEbus master engine.

Each data beat starts when the master raises the data strobe. The block registers a request toward the chosen target and waits for that target's done pulse. It then returns read data and holds an acknowledge until the data strobe drops. Parity is even, with one bit per byte lane, and it is checked on the address and on write data. The two checks act differently. A bad address makes the block ignore the cycle completely. Bad write data is answered with a bus error. Multi-beat transfers (synchronous, 64-bit and block) advance the target address after each beat. For a window whose target cannot take block transfers, the transfer goes out toward VMEbus as a series of plain single cycles.

Top module: `ext_slave_router`

## Requirements
- R1: A cycle in A16 space (space code 0) with the configuration hit set is routed to the register file only (`reg_req`). This holds even when other hits are also set.
- R2: A cycle in A24 (code 1) or A32 (code 2) space with the memory hit set goes to the register file when `mem_sel_reg` is 1 and to DRAM (`dram_req`) when it is 0. The memory hit is not honoured in A16 space.
- R3: A claimed cycle with only the window hit set raises `vme_req`. Priority is configuration, then memory, then window. At most one target request is high at any time.
- R4: Single (kind 0) and read-modify-write (kind 1) cycles are accepted in all three spaces with size codes 0 (8-bit), 1 (16-bit) and 2 (32-bit). Size code 3 is not claimed unless the kind is 64-bit. `tgt_size` repeats the size code, `tgt_we` repeats the direction, and `tgt_lock` is 1 only for read-modify-write.
- R5: Synchronous (kind 2), 64-bit (kind 3) and block (kind 4) cycles in A16 space are not claimed. No request, acknowledge or bus error is given for them.
- R6: A cycle whose address fails the even parity check is ignored. No request, acknowledge or bus error is given until the address strobe is released.
- R7: A write beat whose data fails the even parity check gets `ext_berr`. It issues no target request and never gets `ext_ack`.
- R8: Data parity is not checked on read beats. A read with bad data parity completes normally with the target's data.
- R9: In a multi-beat cycle the target address grows after each beat by 1, 2 or 4 bytes for size codes 0, 1 and 2, and by 8 bytes for kind 3. The transfer ends when the master releases the address strobe.
- R10: A multi-beat cycle routed to a window raises `vme_block` with each request. If that window's bit in `win_noblock` is set, `vme_block` stays 0 and each beat is a separate single cycle.
- R11: After reset, every request, acknowledge, bus error and `vme_block` output is 0.
- R12: A cycle with no usable hit is not claimed, for example a configuration hit outside A16 space or no hit at all. No response is given for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_as | input | 1 | Extension bus address strobe |
| ext_ds | input | 1 | Extension bus data strobe (one pulse per beat) |
| ext_we | input | 1 | 1 = write cycle |
| ext_space | input | 2 | Address space: 0 A16, 1 A24, 2 A32, 3 reserved |
| ext_kind | input | 3 | 0 single, 1 RMW, 2 synchronous, 3 64-bit, 4 block |
| ext_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| ext_addr | input | AW | Cycle address |
| ext_apar | input | AW/8 | Even parity, one bit per address byte |
| ext_wdata | input | DW | Write data |
| ext_dpar | input | DW/8 | Even parity, one bit per data byte |
| ext_ack | output | 1 | Beat acknowledge |
| ext_berr | output | 1 | Bus error response |
| ext_rdata | output | DW | Read data returned to the master |
| hit_cfg | input | 1 | Configuration-space decoder hit |
| hit_mem | input | 1 | Memory decoder hit |
| mem_sel_reg | input | 1 | Memory decoder picks registers (1) or DRAM (0) |
| hit_win | input | 1 | Window decoder hit |
| win_sel | input | WSEL_W | Index of the hit window |
| win_noblock | input | NWIN | Per window: target cannot take block transfers |
| reg_req | output | 1 | Register file access request |
| reg_done | input | 1 | Register file completion pulse |
| reg_rdata | input | DW | Register file read data |
| dram_req | output | 1 | DRAM access request |
| dram_done | input | 1 | DRAM completion pulse |
| dram_rdata | input | DW | DRAM read data |
| vme_req | output | 1 | Request to the VMEbus master engine |
| vme_block | output | 1 | Request is part of a block transfer |
| vme_done | input | 1 | VMEbus engine completion pulse |
| vme_rdata | input | DW | VMEbus engine read data |
| tgt_addr | output | AW | Target address of the current beat |
| tgt_we | output | 1 | Target write flag |
| tgt_wdata | output | DW | Target write data |
| tgt_size | output | 2 | Target transfer size code |
| tgt_lock | output | 1 | Read-modify-write lock |

## Verification
Single cycles are run in every space with different mixes of decoder hits. This shows both which target is chosen and the priority order when several hits are set at once. Cycles with a corrupted address and with corrupted write or read data separate the three parity outcomes: the cycle is ignored, a bus error is returned, or the beat completes normally. Multi-beat runs use different sizes, kinds and targets, with the no-block flag set and clear. They show the per-beat address step, the end of the burst when the strobe drops, and how `vme_block` follows the window flag. Unclaimable combinations, such as burst kinds in A16 space, a reserved size, or hits outside their space, must stay completely silent.

// File: rtl/ext_router_pkg.sv
package ext_router_pkg;

  localparam logic [1:0] SP_A16 = 2'd0;
  localparam logic [1:0] SP_A24 = 2'd1;
  localparam logic [1:0] SP_A32 = 2'd2;
  localparam logic [1:0] SP_RSV = 2'd3;

  localparam logic [2:0] K_SINGLE = 3'd0;
  localparam logic [2:0] K_RMW    = 3'd1;
  localparam logic [2:0] K_SYNC   = 3'd2;
  localparam logic [2:0] K_D64    = 3'd3;
  localparam logic [2:0] K_BLOCK  = 3'd4;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_REG  = 2'd1,
    DST_DRAM = 2'd2,
    DST_VME  = 2'd3
  } dest_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DECODE = 3'd1,
    ST_DATA   = 3'd2,
    ST_ISSUE  = 3'd3,
    ST_ACK    = 3'd4,
    ST_BERR   = 3'd5,
    ST_DONE   = 3'd6,
    ST_SKIP   = 3'd7
  } state_e;

  // Kinds that carry more than one data beat per address phase.
  function automatic logic is_burst(input logic [2:0] kind);
    return (kind == K_SYNC) || (kind == K_D64) || (kind == K_BLOCK);
  endfunction

  // Byte distance between consecutive beats.
  function automatic logic [3:0] beat_step(input logic [2:0] kind,
                                           input logic [1:0] size);
    if (kind == K_D64) return 4'd8;
    case (size)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/ext_parity_chk.sv
module ext_parity_chk #(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] data,
  input  logic [LANES-1:0]   par,
  output logic               bad
);
  logic [LANES-1:0] lane_odd;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      // Even parity: the byte plus its parity bit must hold an even count of ones.
      assign lane_odd[g] = ^{par[g], data[g*8 +: 8]};
    end
  endgenerate

  assign bad = |lane_odd;
endmodule

// File: rtl/ext_claim_dec.sv
module ext_claim_dec
  import ext_router_pkg::*;
(
  input  logic [1:0] space,
  input  logic [2:0] kind,
  input  logic [1:0] size,
  input  logic       hit_cfg,
  input  logic       hit_mem,
  input  logic       mem_sel_reg,
  input  logic       hit_win,
  output dest_e      dest
);
  logic legal;

  always_comb begin
    legal = 1'b1;
    if (space == SP_RSV)                      legal = 1'b0;
    if (kind > K_BLOCK)                       legal = 1'b0;
    if (is_burst(kind) && space == SP_A16)    legal = 1'b0;
    if (kind != K_D64 && size == 2'd3)        legal = 1'b0;

    dest = DST_NONE;
    if (legal) begin
      if (hit_cfg && space == SP_A16)
        dest = DST_REG;
      else if (hit_mem && space != SP_A16)
        dest = mem_sel_reg ? DST_REG : DST_DRAM;
      else if (hit_win)
        dest = DST_VME;
    end
  end
endmodule

// File: rtl/ext_addr_step.sv
module ext_addr_step
  import ext_router_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          adv,
  input  logic [2:0]    kind,
  input  logic [1:0]    size,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] step_ext;

  assign step_ext = {{(AW-4){1'b0}}, beat_step(kind, size)};

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= load_addr;
    else if (adv)  addr <= addr + step_ext;
  end
endmodule

// File: rtl/ext_slave_router.sv
module ext_slave_router
  import ext_router_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int NWIN   = 4,
  parameter int WSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_as,
  input  logic              ext_ds,
  input  logic              ext_we,
  input  logic [1:0]        ext_space,
  input  logic [2:0]        ext_kind,
  input  logic [1:0]        ext_size,
  input  logic [AW-1:0]     ext_addr,
  input  logic [AW/8-1:0]   ext_apar,
  input  logic [DW-1:0]     ext_wdata,
  input  logic [DW/8-1:0]   ext_dpar,
  output logic              ext_ack,
  output logic              ext_berr,
  output logic [DW-1:0]     ext_rdata,
  input  logic              hit_cfg,
  input  logic              hit_mem,
  input  logic              mem_sel_reg,
  input  logic              hit_win,
  input  logic [WSEL_W-1:0] win_sel,
  input  logic [NWIN-1:0]   win_noblock,
  output logic              reg_req,
  input  logic              reg_done,
  input  logic [DW-1:0]     reg_rdata,
  output logic              dram_req,
  input  logic              dram_done,
  input  logic [DW-1:0]     dram_rdata,
  output logic              vme_req,
  output logic              vme_block,
  input  logic              vme_done,
  input  logic [DW-1:0]     vme_rdata,
  output logic [AW-1:0]     tgt_addr,
  output logic              tgt_we,
  output logic [DW-1:0]     tgt_wdata,
  output logic [1:0]        tgt_size,
  output logic              tgt_lock
);
  localparam int ALANES = AW / 8;
  localparam int DLANES = DW / 8;

  state_e            st;
  dest_e             dest_c, dest_q;
  logic [1:0]        space_q, size_q;
  logic [2:0]        kind_q;
  logic              we_q, burst_q;
  logic              hit_cfg_q, hit_mem_q, msel_q, hit_win_q;
  logic [WSEL_W-1:0] win_q;
  logic              apar_bad, apar_bad_q, dpar_bad;
  logic              done_sel;
  logic [DW-1:0]     rdata_sel;
  logic              load_addr, adv_addr;

  // Address parity is judged on the live bus in the capture cycle.
  ext_parity_chk #(.LANES(ALANES)) u_apar (
    .data(ext_addr), .par(ext_apar), .bad(apar_bad)
  );

  ext_parity_chk #(.LANES(DLANES)) u_dpar (
    .data(ext_wdata), .par(ext_dpar), .bad(dpar_bad)
  );

  ext_claim_dec u_claim (
    .space(space_q), .kind(kind_q), .size(size_q),
    .hit_cfg(hit_cfg_q), .hit_mem(hit_mem_q), .mem_sel_reg(msel_q),
    .hit_win(hit_win_q), .dest(dest_c)
  );

  assign load_addr = (st == ST_IDLE) && ext_as;
  assign adv_addr  = (st == ST_ACK) && !ext_ds && ext_as && burst_q;

  ext_addr_step #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .load(load_addr), .load_addr(ext_addr),
    .adv(adv_addr), .kind(kind_q), .size(size_q), .addr(tgt_addr)
  );

  always_comb begin
    case (dest_q)
      DST_REG:  begin done_sel = reg_done;  rdata_sel = reg_rdata;  end
      DST_DRAM: begin done_sel = dram_done; rdata_sel = dram_rdata; end
      DST_VME:  begin done_sel = vme_done;  rdata_sel = vme_rdata;  end
      default:  begin done_sel = 1'b0;      rdata_sel = '0;         end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      dest_q     <= DST_NONE;
      space_q    <= SP_A16;
      size_q     <= 2'd0;
      kind_q     <= K_SINGLE;
      we_q       <= 1'b0;
      burst_q    <= 1'b0;
      hit_cfg_q  <= 1'b0;
      hit_mem_q  <= 1'b0;
      msel_q     <= 1'b0;
      hit_win_q  <= 1'b0;
      win_q      <= '0;
      apar_bad_q <= 1'b0;
      ext_ack    <= 1'b0;
      ext_berr   <= 1'b0;
      ext_rdata  <= '0;
      reg_req    <= 1'b0;
      dram_req   <= 1'b0;
      vme_req    <= 1'b0;
      vme_block  <= 1'b0;
      tgt_we     <= 1'b0;
      tgt_wdata  <= '0;
      tgt_size   <= 2'd0;
      tgt_lock   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (ext_as) begin
            space_q    <= ext_space;
            kind_q     <= ext_kind;
            size_q     <= ext_size;
            we_q       <= ext_we;
            hit_cfg_q  <= hit_cfg;
            hit_mem_q  <= hit_mem;
            msel_q     <= mem_sel_reg;
            hit_win_q  <= hit_win;
            win_q      <= win_sel;
            apar_bad_q <= apar_bad;
            st         <= ST_DECODE;
          end
        end

        ST_DECODE: begin
          if (!ext_as)
            st <= ST_IDLE;
          else if (apar_bad_q || dest_c == DST_NONE)
            st <= ST_SKIP;
          else begin
            dest_q   <= dest_c;
            burst_q  <= is_burst(kind_q);
            tgt_we   <= we_q;
            tgt_size <= size_q;
            tgt_lock <= (kind_q == K_RMW);
            st       <= ST_DATA;
          end
        end

        ST_DATA: begin
          if (!ext_as)
            st <= ST_IDLE;
          else if (ext_ds) begin
            if (we_q && dpar_bad) begin
              ext_berr <= 1'b1;
              st       <= ST_BERR;
            end else begin
              tgt_wdata <= ext_wdata;
              reg_req   <= (dest_q == DST_REG);
              dram_req  <= (dest_q == DST_DRAM);
              vme_req   <= (dest_q == DST_VME);
              vme_block <= (dest_q == DST_VME) && burst_q && !win_noblock[win_q];
              st        <= ST_ISSUE;
            end
          end
        end

        ST_ISSUE: begin
          // A started target access always runs to its completion pulse.
          if (done_sel) begin
            reg_req   <= 1'b0;
            dram_req  <= 1'b0;
            vme_req   <= 1'b0;
            vme_block <= 1'b0;
            ext_rdata <= we_q ? '0 : rdata_sel;
            ext_ack   <= 1'b1;
            st        <= ST_ACK;
          end
        end

        ST_ACK: begin
          if (!ext_ds) begin
            ext_ack <= 1'b0;
            if (!ext_as)     st <= ST_IDLE;
            else if (burst_q) st <= ST_DATA;
            else             st <= ST_DONE;
          end
        end

        ST_BERR: begin
          if (!ext_ds) begin
            ext_berr <= 1'b0;
            st       <= ext_as ? ST_DONE : ST_IDLE;
          end
        end

        default: begin
          if (!ext_as) st <= ST_IDLE;
        end
      endcase
    end
  end

  // ---------------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------------
  assert_one_target_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reg_req, dram_req, vme_req}));

  assert_cfg_to_reg_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ISSUE && hit_cfg_q && space_q == SP_A16) |-> reg_req);

  assert_dram_not_a16_R2: assert property (@(posedge clk) disable iff (rst)
    dram_req |-> (space_q != SP_A16));

  assert_a16_burst_unclaimed_R5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && space_q == SP_A16 && is_burst(kind_q))
      |=> (st == ST_SKIP || st == ST_IDLE));

  assert_addr_parity_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DECODE && apar_bad_q) |=> (st == ST_SKIP || st == ST_IDLE));

  assert_skip_silent_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SKIP) |-> (!ext_ack && !ext_berr && !reg_req && !dram_req && !vme_req));

  assert_berr_only_write_R7: assert property (@(posedge clk) disable iff (rst)
    ext_berr |-> we_q);

  assert_ack_berr_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    !(ext_ack && ext_berr));

  assert_addr_step_R9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACK && !ext_ds && ext_as && burst_q)
      |=> (tgt_addr == $past(tgt_addr) + {{(AW-4){1'b0}}, beat_step(kind_q, size_q)}));

  assert_split_flag_R10: assert property (@(posedge clk) disable iff (rst)
    vme_block |-> (vme_req && burst_q && !win_noblock[win_q]));

endmodule

// File: tb/ext_slave_router_test.sv
`timescale 1ns/1ps
module ext_slave_router_test;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NWIN = 4;
  localparam int WSEL_W = 2;
  localparam logic [DW-1:0] REG_D  = 32'hCAFE_0001;
  localparam logic [DW-1:0] DRAM_D = 32'hD0D0_0002;
  localparam logic [DW-1:0] VME_D  = 32'h7E7E_0003;
  // destination codes used by the bench
  localparam int D_NONE = 0, D_REG = 1, D_DRAM = 2, D_VME = 3;

  logic clk = 0, rst = 1;
  logic ext_as = 0, ext_ds = 0, ext_we = 0;
  logic [1:0] ext_space = 0, ext_size = 0;
  logic [2:0] ext_kind = 0;
  logic [AW-1:0] ext_addr = 0;
  logic [AW/8-1:0] ext_apar = 0;
  logic [DW-1:0] ext_wdata = 0;
  logic [DW/8-1:0] ext_dpar = 0;
  logic ext_ack, ext_berr;
  logic [DW-1:0] ext_rdata;
  logic hit_cfg = 0, hit_mem = 0, mem_sel_reg = 0, hit_win = 0;
  logic [WSEL_W-1:0] win_sel = 0;
  logic [NWIN-1:0] win_noblock = 0;
  logic reg_req, dram_req, vme_req, vme_block;
  logic reg_done = 0, dram_done = 0, vme_done = 0;
  logic [AW-1:0] tgt_addr;
  logic tgt_we, tgt_lock;
  logic [DW-1:0] tgt_wdata;
  logic [1:0] tgt_size;

  int checks = 0, errors = 0;
  logic [1:0] cur_size;
  logic cur_we;

  always #4 clk = ~clk;

  ext_slave_router #(.AW(AW), .DW(DW), .NWIN(NWIN), .WSEL_W(WSEL_W)) uut (
    .clk(clk), .rst(rst), .ext_as(ext_as), .ext_ds(ext_ds), .ext_we(ext_we),
    .ext_space(ext_space), .ext_kind(ext_kind), .ext_size(ext_size),
    .ext_addr(ext_addr), .ext_apar(ext_apar), .ext_wdata(ext_wdata),
    .ext_dpar(ext_dpar), .ext_ack(ext_ack), .ext_berr(ext_berr),
    .ext_rdata(ext_rdata), .hit_cfg(hit_cfg), .hit_mem(hit_mem),
    .mem_sel_reg(mem_sel_reg), .hit_win(hit_win), .win_sel(win_sel),
    .win_noblock(win_noblock), .reg_req(reg_req), .reg_done(reg_done),
    .reg_rdata(REG_D), .dram_req(dram_req), .dram_done(dram_done),
    .dram_rdata(DRAM_D), .vme_req(vme_req), .vme_block(vme_block),
    .vme_done(vme_done), .vme_rdata(VME_D), .tgt_addr(tgt_addr),
    .tgt_we(tgt_we), .tgt_wdata(tgt_wdata), .tgt_size(tgt_size),
    .tgt_lock(tgt_lock)
  );

  function automatic logic [3:0] even_par(input logic [31:0] v);
    for (int i = 0; i < 4; i++) even_par[i] = ^v[i*8 +: 8];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic start(input logic [1:0] sp, input logic [2:0] kd, input logic [1:0] sz,
                       input logic we, input logic [31:0] a, input bit abad,
                       input logic hc, input logic hm, input logic ms, input logic hw,
                       input logic [1:0] ws);
    @(negedge clk);
    ext_space = sp; ext_kind = kd; ext_size = sz; ext_we = we;
    ext_addr = a; ext_apar = even_par(a) ^ {3'b0, abad};
    hit_cfg = hc; hit_mem = hm; mem_sel_reg = ms; hit_win = hw; win_sel = ws;
    cur_size = sz; cur_we = we;
    ext_as = 1;
  endtask

  task automatic finish_cycle();
    @(negedge clk);
    ext_as = 0; ext_ds = 0;
    hit_cfg = 0; hit_mem = 0; hit_win = 0;
    repeat (2) @(negedge clk);
  endtask

  // One data beat with its full handshake.
  task automatic beat(input int dst, input logic [31:0] exp_addr, input logic [31:0] wd,
                      input bit dbad, input bit exp_berr, input int exp_blk,
                      input bit exp_lock, input string req);
    int n;
    ext_wdata = wd; ext_dpar = even_par(wd) ^ {3'b0, dbad};
    ext_ds = 1;
    n = 0;
    do begin @(negedge clk); n++; end
    while (!(reg_req || dram_req || vme_req || ext_berr) && n < 20);
    if (exp_berr) begin
      check(ext_berr && !reg_req && !dram_req && !vme_req, req, "berr without request",
            {reg_req, dram_req, vme_req, ext_berr}, 4'b0001);
      repeat (2) @(negedge clk);
      check(!ext_ack, req, "no ack after berr", ext_ack, 0);
      ext_ds = 0;
      repeat (2) @(negedge clk);
      check(!ext_berr, req, "berr released", ext_berr, 0);
      return;
    end
    check({reg_req, dram_req, vme_req} == (dst == D_REG ? 3'b100 : dst == D_DRAM ? 3'b010 : 3'b001),
          req, "target select", {reg_req, dram_req, vme_req}, dst);
    check(tgt_addr == exp_addr, req, "target address", tgt_addr, exp_addr);
    check(tgt_size == cur_size && tgt_we == cur_we && tgt_lock == exp_lock, req,
          "size/we/lock", {tgt_size, tgt_we, tgt_lock}, {cur_size, cur_we, exp_lock});
    if (exp_blk != 2) check(vme_block == exp_blk[0], req, "vme_block", vme_block, exp_blk);
    if (cur_we) check(tgt_wdata == wd, req, "write data", tgt_wdata, wd);
    reg_done = reg_req; dram_done = dram_req; vme_done = vme_req;
    @(negedge clk);
    reg_done = 0; dram_done = 0; vme_done = 0;
    @(negedge clk);
    check(ext_ack && !ext_berr, req, "ack", {ext_ack, ext_berr}, 2'b10);
    if (!cur_we)
      check(ext_rdata == (dst == D_REG ? REG_D : dst == D_DRAM ? DRAM_D : VME_D), req,
            "read data", ext_rdata, (dst == D_REG ? REG_D : dst == D_DRAM ? DRAM_D : VME_D));
    ext_ds = 0;
    repeat (2) @(negedge clk);
    check(!ext_ack, req, "ack released", ext_ack, 0);
  endtask

  // Raise the data strobe and confirm nothing answers.
  task automatic expect_silent(input string req);
    bit quiet = 1;
    ext_ds = 1;
    ext_wdata = 32'h1234_5678; ext_dpar = even_par(32'h1234_5678);
    repeat (10) begin
      @(negedge clk);
      if (reg_req || dram_req || vme_req || ext_ack || ext_berr) quiet = 0;
    end
    check(quiet, req, "cycle ignored", {reg_req, dram_req, vme_req, ext_ack, ext_berr}, 0);
    finish_cycle();
  endtask

  task automatic t_reset();
    check({reg_req, dram_req, vme_req, vme_block, ext_ack, ext_berr} == 0, "R11",
          "outputs after reset", {reg_req, dram_req, vme_req, vme_block, ext_ack, ext_berr}, 0);
  endtask

  task automatic t_cfg();
    start(2'd0, 3'd0, 2'd1, 0, 32'h0000_C040, 0, 1, 1, 0, 1, 2'd0);
    beat(D_REG, 32'h0000_C040, 0, 0, 0, 2, 0, "R1");
    finish_cycle();
  endtask

  task automatic t_mem();
    start(2'd1, 3'd0, 2'd2, 1, 32'h0020_0010, 0, 0, 1, 1, 0, 2'd0);
    beat(D_REG, 32'h0020_0010, 32'hA5A5_0F0F, 0, 0, 2, 0, "R2");
    finish_cycle();
    start(2'd2, 3'd0, 2'd2, 0, 32'h4000_2000, 0, 0, 1, 0, 1, 2'd1);
    beat(D_DRAM, 32'h4000_2000, 0, 0, 0, 2, 0, "R2");
    finish_cycle();
  endtask

  task automatic t_win();
    start(2'd2, 3'd0, 2'd2, 0, 32'h8000_0104, 0, 0, 0, 0, 1, 2'd3);
    beat(D_VME, 32'h8000_0104, 0, 0, 0, 0, 0, "R3");
    finish_cycle();
    start(2'd0, 3'd0, 2'd2, 0, 32'h0000_C000, 0, 1, 0, 0, 1, 2'd0);
    beat(D_REG, 32'h0000_C000, 0, 0, 0, 2, 0, "R3");
    finish_cycle();
  endtask

  task automatic t_widths();
    start(2'd0, 3'd1, 2'd0, 1, 32'h0000_1233, 0, 0, 0, 0, 1, 2'd1);
    beat(D_VME, 32'h0000_1233, 32'h0000_00EE, 0, 0, 0, 1, "R4");
    finish_cycle();
    start(2'd1, 3'd0, 2'd1, 0, 32'h00AB_0002, 0, 0, 1, 0, 0, 2'd0);
    beat(D_DRAM, 32'h00AB_0002, 0, 0, 0, 2, 0, "R4");
    finish_cycle();
    start(2'd2, 3'd0, 2'd3, 0, 32'h00AB_0004, 0, 0, 1, 0, 0, 2'd0);
    expect_silent("R4");
  endtask

  task automatic t_a16_burst();
    start(2'd0, 3'd4, 2'd2, 0, 32'h0000_0400, 0, 1, 0, 0, 1, 2'd0);
    expect_silent("R5");
    start(2'd0, 3'd3, 2'd2, 1, 32'h0000_0800, 0, 0, 0, 0, 1, 2'd0);
    expect_silent("R5");
  endtask

  task automatic t_apar();
    start(2'd2, 3'd0, 2'd2, 1, 32'h1000_0000, 1, 0, 1, 0, 0, 2'd0);
    expect_silent("R6");
    start(2'd2, 3'd0, 2'd2, 1, 32'h1000_0000, 0, 0, 1, 0, 0, 2'd0);
    beat(D_DRAM, 32'h1000_0000, 32'h0BAD_F00D, 0, 0, 2, 0, "R6");
    finish_cycle();
  endtask

  task automatic t_dpar();
    start(2'd1, 3'd0, 2'd2, 1, 32'h0030_0000, 0, 0, 1, 0, 0, 2'd0);
    beat(D_DRAM, 0, 32'h5555_AAAA, 1, 1, 2, 0, "R7");
    finish_cycle();
  endtask

  task automatic t_rdpar();
    start(2'd1, 3'd0, 2'd2, 0, 32'h0030_0040, 0, 0, 1, 0, 0, 2'd0);
    beat(D_DRAM, 32'h0030_0040, 32'h5555_AAAA, 1, 0, 2, 0, "R8");
    finish_cycle();
  endtask

  task automatic t_burst();
    start(2'd1, 3'd4, 2'd1, 0, 32'h0040_0100, 0, 0, 1, 0, 0, 2'd0);
    for (int i = 0; i < 3; i++)
      beat(D_DRAM, 32'h0040_0100 + 2 * i, 0, 0, 0, 2, 0, "R9");
    finish_cycle();
    start(2'd2, 3'd3, 2'd2, 1, 32'h0000_0800, 0, 0, 1, 1, 0, 2'd0);
    for (int i = 0; i < 2; i++)
      beat(D_REG, 32'h0000_0800 + 8 * i, 32'h100 + i, 0, 0, 2, 0, "R9");
    finish_cycle();
    start(2'd2, 3'd2, 2'd0, 0, 32'h0000_0010, 0, 0, 1, 1, 0, 2'd0);
    beat(D_REG, 32'h0000_0010, 0, 0, 0, 2, 0, "R9");
    beat(D_REG, 32'h0000_0011, 0, 0, 0, 2, 0, "R9");
    finish_cycle();
  endtask

  task automatic t_split();
    win_noblock = 4'b0100;
    start(2'd2, 3'd2, 2'd2, 0, 32'h9000_0000, 0, 0, 0, 0, 1, 2'd2);
    for (int i = 0; i < 3; i++)
      beat(D_VME, 32'h9000_0000 + 4 * i, 0, 0, 0, 0, 0, "R10");
    finish_cycle();
    start(2'd2, 3'd4, 2'd2, 0, 32'h9000_0100, 0, 0, 0, 0, 1, 2'd1);
    for (int i = 0; i < 2; i++)
      beat(D_VME, 32'h9000_0100 + 4 * i, 0, 0, 0, 1, 0, "R10");
    finish_cycle();
    win_noblock = 0;
  endtask

  task automatic t_nohit();
    start(2'd2, 3'd0, 2'd2, 0, 32'h2000_0000, 0, 0, 0, 0, 0, 2'd0);
    expect_silent("R12");
    start(2'd2, 3'd0, 2'd2, 0, 32'h0000_C000, 0, 1, 0, 0, 0, 2'd0);
    expect_silent("R12");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_mem();
    t_win();
    t_widths();
    t_a16_burst();
    t_apar();
    t_dpar();
    t_rdpar();
    t_burst();
    t_split();
    t_nohit();
    report();
  end
endmodule